// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Break, Loopback and Multidrop

This block sends and receives asynchronous serial characters at the same time, one line in each direction. A programmable divider sets the bit rate. Each character has 6, 7 or 8 data bits, an optional parity bit and one stop bit. The receiver takes 16 samples per bit. It takes the value of each bit as the majority of three samples at the middle of the bit. It reports parity, framing and overrun errors. It also detects a line break and can hold the transmit line low to send one.

Software uses a small register bus to set the block up, send and read characters, read status and choose which status bits drive the interrupt. The channel mode can connect the two serial pins to each other or feed the transmitter back into the receiver, for test. In multidrop mode the parity position carries an address marker. A ready-to-send output and a clear-to-send input give simple flow control.

Top module: `async_serial_unit`

## Requirements
- R1: After reset `txd` is 1, `irq` is 0, `rts_n` is 0, and the status register (address 2) reads 0x82. Status bit positions: 0 = received character ready, 1 = transmit holding register empty, 2 = parity error, 3 = framing error, 4 = overrun, 5 = break seen, 6 = last character was an address, 7 = transmitter fully idle.
- R2: Control register (address 0) bits [1:0] select the character length: 00 = 6 bits, 01 = 7 bits, 1x = 8 bits. Data goes out LSB first, after a 0 start bit. Received data read at address 3 has 0 in the bits above the character length.
- R3: Control bit 2 enables parity and control bit 3 selects odd parity (0 = even). The transmitter puts the parity bit after the data. A received parity bit that does not match sets status bit 2.
- R4: A received stop bit sampled as 0, on a frame that is not all zeros, sets status bit 3 and still delivers the character.
- R5: A character that completes while status bit 0 is still set is discarded. Status bit 4 is set and the previously received data is kept.
- R6: A received line that stays 0 through a whole frame, stop bit included, sets status bit 5 and delivers no character. Reception resumes only after the line returns high.
- R7: Writing command bit 0 (address 2) holds `txd` at 0 until a write of command bit 1.
- R8: Control bits [6:5] = 01 select echo mode: `txd` follows `rxd` and the receiver still receives.
- R9: Control bits [6:5] = 10 select local loopback: the transmitter feeds the receiver and `txd` stays at 1.
- R10: Control bits [6:5] = 11 select remote loopback: `txd` follows `rxd` and the receiver gets nothing.
- R11: When control bit 4 is set (multidrop), the bit after the data is the address marker. Command bit 3 makes the next transmitted character an address (marker 1). A received marker of 1 sets status bit 6 and a marker of 0 clears it. Parity errors are not flagged in this mode.
- R12: The transmitter starts no character while `cts_n` is 1. `rts_n` is 1 exactly while status bit 0 is set.
- R13: A read of address 3 in the same cycle that a character completes leaves the new character ready and sets no overrun.
- R14: `irq` is 1 while any status bit is set whose bit in the mask register (address 4) is 1. Command bit 2 clears status bits 2 to 6. Writes to address 3 load the transmitter, and address 1 sets the divider: one 16x tick every divider+1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on address 3) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq | output | 1 | Interrupt request |
| rxd | input | 1 | Serial receive pin |
| txd | output | 1 | Serial transmit pin |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Ready to send, active low |

## Verification
Two things can happen in the same cycle: software reads the receive data register, and the receiver finishes a new character. Each tries to change the character-ready flag in the opposite direction. The bench provokes this by holding the data-register read strobe high on every cycle while a whole character arrives. It judges the result at the ports. The completion must raise `rts_n` for at least one cycle, no overrun may be flagged, and the data register must afterwards hold the new character.

// File: rtl/async_serial_unit.sv
module async_serial_unit #(
  parameter int DIV_W     = 8,
  parameter int RESET_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       rxd,
  output logic       txd,
  input  logic       cts_n,
  output logic       rts_n
);
  localparam logic [2:0] A_CTRL = 3'd0, A_DIV = 3'd1, A_STAT = 3'd2, A_DATA = 3'd3, A_MASK = 3'd4;

  logic [6:0]       ctrl;
  logic [DIV_W-1:0] div_r, div_cnt;
  logic [7:0]       imask;

  wire [1:0] mode = ctrl[6:5];
  wire       md   = ctrl[4];
  wire       odd  = ctrl[3];
  wire       pen  = ctrl[2];
  wire       has_p = pen | md;
  wire [3:0] nbits = (ctrl[1:0] == 2'd0) ? 4'd6 : (ctrl[1:0] == 2'd1) ? 4'd7 : 4'd8;
  wire [3:0] total = nbits + {3'd0, has_p} + 4'd2;
  wire [7:0] dmask = 8'hFF >> (4'd8 - nbits);
  wire       wr_cmd = wr_en && addr == A_STAT;
  wire       rd_rx  = rd_en && addr == A_DATA;
  wire       tick   = div_cnt >= div_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= 7'h02; div_r <= DIV_W'(RESET_DIV); imask <= '0; div_cnt <= '0;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (wr_en && addr == A_CTRL) ctrl  <= wdata[6:0];
      if (wr_en && addr == A_DIV)  div_r <= DIV_W'(wdata);
      if (wr_en && addr == A_MASK) imask <= wdata;
    end

  // transmitter
  logic [7:0]  thr;
  logic        thr_full, tx_busy, brk, send_addr;
  logic [3:0]  tx_sub, tx_cnt;
  logic [10:0] tx_sr, frame;
  wire [7:0] td   = thr & dmask;
  wire       pbit = md ? send_addr : (^td) ^ odd;
  wire tx_start   = !tx_busy && thr_full && !cts_n && !brk;

  always_comb begin
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nbits)) frame[i+1] = td[i];
    if (has_p) frame[nbits+4'd1] = pbit;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      thr <= '0; thr_full <= 1'b0; tx_busy <= 1'b0; brk <= 1'b0; send_addr <= 1'b0;
      tx_sub <= '0; tx_cnt <= '0; tx_sr <= '1;
    end else begin
      if (tx_start) begin
        tx_sr <= frame; tx_cnt <= total - 4'd1; tx_sub <= '0;
        tx_busy <= 1'b1; thr_full <= 1'b0; send_addr <= 1'b0;
      end else if (tx_busy && tick) begin
        tx_sub <= tx_sub + 4'd1;
        if (tx_sub == 4'd15) begin
          tx_sr <= {1'b1, tx_sr[10:1]};
          if (tx_cnt == 4'd0) tx_busy <= 1'b0;
          else tx_cnt <= tx_cnt - 4'd1;
        end
      end
      if (wr_cmd) begin
        if (wdata[0]) brk <= 1'b1;
        if (wdata[1]) brk <= 1'b0;
        if (wdata[3]) send_addr <= 1'b1;
      end
      if (wr_en && addr == A_DATA) begin thr <= wdata; thr_full <= 1'b1; end
    end

  wire tx_line = brk ? 1'b0 : (tx_busy ? tx_sr[0] : 1'b1);
  assign txd = (mode == 2'd0) ? tx_line : (mode == 2'd2) ? 1'b1 : rxd;

  // receiver
  wire rx_src = (mode == 2'd2) ? tx_line : (mode == 2'd3) ? 1'b1 : rxd;
  logic [1:0]  rs;
  logic        rx_busy, rx_wait_hi, rx_rdy, perr, ferr, ovr, bdet, raddr;
  logic [3:0]  rx_sub, rx_cnt;
  logic [2:0]  smp;
  logic [10:0] rx_sr;
  logic [7:0]  rx_data;
  wire         rx_in = rs[1];
  wire         maj   = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
  wire [10:0]  sr_n  = {maj, rx_sr[10:1]};
  wire [10:0]  fv    = sr_n >> (4'd11 - total);
  wire [7:0]   rdat  = fv[8:1] & dmask;
  wire         rpb   = fv[nbits+4'd1];
  wire         rstop = fv[total-4'd1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rs <= 2'b11; rx_busy <= 1'b0; rx_wait_hi <= 1'b0; rx_rdy <= 1'b0;
      {perr, ferr, ovr, bdet, raddr} <= '0;
      rx_sub <= '0; rx_cnt <= '0; smp <= '0; rx_sr <= '0; rx_data <= '0;
    end else begin
      rs <= {rs[0], rx_src};
      if (wr_cmd && wdata[2]) {perr, ferr, ovr, bdet, raddr} <= '0;
      if (rd_rx) rx_rdy <= 1'b0;
      if (rx_wait_hi) begin
        if (rx_in) rx_wait_hi <= 1'b0;
      end else if (!rx_busy) begin
        if (!rx_in) begin rx_busy <= 1'b1; rx_sub <= '0; rx_cnt <= '0; end
      end else if (tick) begin
        rx_sub <= rx_sub + 4'd1;
        if (rx_sub >= 4'd7 && rx_sub <= 4'd9) smp <= {smp[1:0], rx_in};
        if (rx_sub == 4'd15) begin
          if (rx_cnt == 4'd0 && maj) rx_busy <= 1'b0;
          else begin
            rx_sr <= sr_n;
            if (rx_cnt != total - 4'd1) rx_cnt <= rx_cnt + 4'd1;
            else begin
              rx_busy <= 1'b0;
              if (fv == '0) begin
                bdet <= 1'b1; rx_wait_hi <= 1'b1;
              end else begin
                if (!rstop) ferr <= 1'b1;
                if (rx_rdy && !rd_rx) ovr <= 1'b1;
                else begin
                  rx_data <= rdat; rx_rdy <= 1'b1; raddr <= md & rpb;
                  if (pen && !md && (rpb != ((^rdat) ^ odd))) perr <= 1'b1;
                end
              end
            end
          end
        end
      end
    end

  wire [7:0] status = {!tx_busy && !thr_full, raddr, bdet, ovr, ferr, perr, !thr_full, rx_rdy};
  assign irq   = |(status & imask);
  assign rts_n = rx_rdy;

  always_comb
    case (addr)
      A_CTRL:  rdata = {1'b0, ctrl};
      A_DIV:   rdata = 8'(div_r);
      A_STAT:  rdata = status;
      A_DATA:  rdata = rx_data;
      A_MASK:  rdata = imask;
      default: rdata = '0;
    endcase

  a_r7_break_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && mode == 2'd0) |-> !txd);
  a_r9_local_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> txd);
  a_r10_remote_wire: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (txd == rxd));
  a_r12_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !$past(cts_n));
  a_r5_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(rx_data));
  a_r6_break_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bdet) |-> $stable(rx_data));
endmodule

// File: tb/async_serial_unit_test.sv
module async_serial_unit_test;
  localparam int CLK_P = 10;
  localparam int DIVV  = 1;
  localparam int BIT   = 16 * (DIVV + 1);

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, rxd = 1, cts_n = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic irq, txd, rts_n;
  int checks = 0, fails = 0;

  async_serial_unit uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rxd(rxd), .txd(txd), .cts_n(cts_n), .rts_n(rts_n));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit hp, input bit pb,
                      input bit stop, output int mism);
    logic [10:0] fb = '1;
    int n = nb + 1;
    mism = 0;
    fb[0] = 1'b0;
    for (int i = 0; i < nb; i++) fb[i+1] = d[i];
    if (hp) begin fb[n] = pb; n++; end
    fb[n] = stop; n++;
    for (int i = 0; i < n; i++) begin
      rxd = fb[i];
      repeat (BIT/2) @(negedge clk);
      if (txd !== fb[i]) mism++;
      repeat (BIT/2) @(negedge clk);
    end
    rxd = 1;
    repeat (2*BIT) @(negedge clk);
  endtask

  task automatic capture(input int n, output logic [10:0] bits);
    int t = 0;
    bits = '0;
    while (txd !== 1'b0 && t < 4000) begin @(negedge clk); t++; end
    repeat (BIT/2) @(negedge clk);
    for (int i = 0; i < n; i++) begin bits[i] = txd; repeat (BIT) @(negedge clk); end
  endtask

  task automatic count_low(input int cyc, output int lows);
    lows = 0;
    for (int i = 0; i < cyc; i++) begin @(negedge clk); if (!txd) lows++; end
  endtask

  task automatic t_reset;
    logic [7:0] s;
    rd(3'd2, s);
    check("R1 status", s, 8'h82);
    check("R1 txd", txd, 1);
    check("R1 irq", irq, 0);
    check("R12 rts_n idle", rts_n, 0);
  endtask

  task automatic t_rx8;
    logic [7:0] s, d; int m;
    wr(3'd0, 8'h02); wr(3'd1, 8'(DIVV));
    send(8'hA5, 8, 0, 0, 1, m);
    rd(3'd2, s); check("R2 status after 8-bit char", s, 8'h83);
    check("R12 rts_n ready", rts_n, 1);
    rd(3'd3, d); check("R2 8-bit data", d, 8'hA5);
    rd(3'd2, s); check("R12 ready clears on read", s[0], 0);
  endtask

  task automatic t_rx7par;
    logic [7:0] s, d; int m;
    wr(3'd0, 8'h0D);
    send(8'h55, 7, 1, 0, 1, m);
    rd(3'd2, s); check("R3 odd parity error", s[2], 1);
    rd(3'd3, d); check("R2 7-bit data", d, 8'h55);
    wr(3'd2, 8'h04);
    send(8'hFF, 7, 1, 0, 1, m);
    rd(3'd2, s); check("R3 good odd parity", s[2], 0);
    rd(3'd3, d); check("R2 7-bit upper bit zero", d, 8'h7F);
  endtask

  task automatic t_frame;
    logic [7:0] s, d; int m;
    wr(3'd0, 8'h02);
    send(8'h3C, 8, 0, 0, 0, m);
    rd(3'd2, s); check("R4 framing error", s[3], 1);
    check("R4 char delivered", s[0], 1);
    rd(3'd3, d); check("R4 data", d, 8'h3C);
    wr(3'd2, 8'h04);
  endtask

  task automatic t_break_rx;
    logic [7:0] s, d;
    rxd = 0; repeat (12*BIT) @(negedge clk);
    rxd = 1; repeat (3*BIT) @(negedge clk);
    rd(3'd2, s); check("R6 break flag, no char", s & 8'h21, 8'h20);
    rd(3'd3, d); check("R6 data untouched", d, 8'h3C);
    wr(3'd2, 8'h04);
  endtask

  task automatic t_overrun;
    logic [7:0] s, d; int m;
    send(8'h11, 8, 0, 0, 1, m);
    send(8'h22, 8, 0, 0, 1, m);
    rd(3'd2, s); check("R5 overrun flag", s[4], 1);
    rd(3'd3, d); check("R5 old data kept", d, 8'h11);
    wr(3'd2, 8'h04);
  endtask

  task automatic t_tx6;
    logic [10:0] b;
    wr(3'd0, 8'h04);
    wr(3'd3, 8'hC7);
    capture(9, b); check("R2 R3 6-bit even frame", b[8:0], 9'h18E);
  endtask

  task automatic t_tx_break;
    int lows;
    wr(3'd0, 8'h02);
    wr(3'd2, 8'h01);
    count_low(100, lows); check("R7 held low", lows, 100);
    wr(3'd2, 8'h02);
    @(negedge clk); check("R7 released", txd, 1);
  endtask

  task automatic t_cts;
    logic [7:0] s; logic [10:0] b; int lows;
    cts_n = 1;
    wr(3'd3, 8'h5A);
    count_low(3*BIT, lows); check("R12 no start under cts_n", lows, 0);
    rd(3'd2, s); check("R12 holding still full", s[1], 0);
    cts_n = 0;
    capture(10, b); check("R12 frame after cts", b[9:0], 10'h2B4);
  endtask

  task automatic t_local;
    logic [7:0] s, d; int lows;
    repeat (2*BIT) @(negedge clk);
    wr(3'd0, 8'h42);
    wr(3'd3, 8'h96);
    count_low(12*BIT, lows); check("R9 pin stays high", lows, 0);
    rd(3'd2, s); check("R9 char looped", s[0], 1);
    rd(3'd3, d); check("R9 looped data", d, 8'h96);
  endtask

  task automatic t_remote;
    logic [7:0] s; int m;
    wr(3'd0, 8'h62);
    send(8'h3A, 8, 0, 0, 1, m);
    check("R10 txd follows rxd", m, 0);
    rd(3'd2, s); check("R10 receiver cut off", s[0], 0);
  endtask

  task automatic t_echo;
    logic [7:0] d; int m;
    wr(3'd0, 8'h22);
    send(8'hE1, 8, 0, 0, 1, m);
    check("R8 echo on txd", m, 0);
    rd(3'd3, d); check("R8 receiver still gets char", d, 8'hE1);
  endtask

  task automatic t_multidrop;
    logic [7:0] s, d; logic [10:0] b; int m;
    wr(3'd0, 8'h12);
    wr(3'd2, 8'h08); wr(3'd3, 8'h3C);
    capture(11, b); check("R11 address marker 1", b, 11'h678);
    repeat (BIT) @(negedge clk);
    wr(3'd3, 8'h3C);
    capture(11, b); check("R11 data marker 0", b, 11'h478);
    repeat (BIT) @(negedge clk);
    send(8'h12, 8, 1, 1, 1, m);
    rd(3'd2, s); check("R11 rx address flag", s[6], 1);
    check("R11 no parity error", s[2], 0);
    rd(3'd3, d); check("R11 address data", d, 8'h12);
    send(8'h34, 8, 1, 0, 1, m);
    rd(3'd2, s); check("R11 rx data flag clear", s[6], 0);
    rd(3'd3, d);
    wr(3'd0, 8'h02);
  endtask

  task automatic t_irq;
    logic [7:0] d; int m;
    check("R14 irq low, nothing masked", irq, 0);
    wr(3'd4, 8'h01);
    check("R14 irq low, nothing ready", irq, 0);
    send(8'h77, 8, 0, 0, 1, m);
    check("R14 irq on ready", irq, 1);
    rd(3'd3, d);
    check("R14 irq drops after read", irq, 0);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] s, d; int m, seen = 0; bit done = 0;
    @(negedge clk); addr = 3'd3; rd_en = 1;
    repeat (2) @(negedge clk);
    fork
      begin send(8'h42, 8, 0, 0, 1, m); done = 1; end
      begin while (!done) begin @(negedge clk); if (rts_n) seen++; end end
    join
    rd_en = 0;
    check("R13 completion visible during read", seen != 0, 1);
    rd(3'd2, s); check("R13 no overrun", s[4], 0);
    rd(3'd3, d); check("R13 new data", d, 8'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rx8();
    t_rx7par();
    t_frame();
    t_break_rx();
    t_overrun();
    t_tx6();
    t_tx_break();
    t_cts();
    t_local();
    t_remote();
    t_echo();
    t_multidrop();
    t_irq();
    t_collide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule